// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block sits between a host's memory strobes and a battery-backed static memory. It keeps the memory safe while the supply fails and while it comes back. When the synchronised power-fail-detect input rises, an access that is already under way may finish. Protection is then forced, either when that access ends or when a bounded drain window runs out, whichever comes first. From that point the gated chip enable, gated write enable and output enable are all held inactive. The memory data pins therefore float, and host strobes have no effect.

After the supply is back above the detect threshold, a long hold-off keeps protection on so that the host can settle. Normal access resumes only when the hold-off expires. A separate output selects the battery path whenever the supply is below the backup-cell level. That path stays isolated from reset until the supply has been seen valid once.

The timings are clock-cycle counts. By default they are derived from the clock rate, a drain timeout in microseconds (allowed range 40 to 150, default 100) and a hold-off in milliseconds (allowed range 40 to 120, default 80). A bench can override the counts directly.

Top module: `pfwp_seq`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `wp_o` is 1, `ce_n_o`, `we_n_o` and `oe_n_o` are 1, and `bat_en_o` is 0.
- R2: Whenever `wp_o` is 1, `ce_n_o`, `we_n_o` and `oe_n_o` are all 1, whatever the strobe inputs are.
- R3: While unprotected, each gated strobe output equals its input as sampled at the previous clock edge (one register of latency), and `wp_o` is 0.
- R4: If `pf_det_i` is sampled 1 while unprotected and `ce_n_i` is sampled 1, `wp_o` becomes 1 at that same edge.
- R5: If `pf_det_i` is sampled 1 while unprotected and `ce_n_i` is sampled 0, the access continues unprotected with strobes passed through. Protection is set at the first edge that samples a 0-to-1 change on `ce_n_i` or on `we_n_i`.
- R6: If no such change arrives, `wp_o` is forced to 1 at the WPT_CYCLES-th clock edge after the detection edge.
- R7: Once `pf_det_i` is sampled 0 while protected, `wp_o` stays 1 and falls at the CER_CYCLES-th edge after that first low sample, provided `pf_det_i` stays 0.
- R8: If `pf_det_i` is sampled 1 during the hold-off, `wp_o` stays 1. The next hold-off then runs its full CER_CYCLES length from the start.
- R9: From reset until `pf_det_i` is first sampled 0, `bat_en_o` stays 0 regardless of `vso_low_i`.
- R10: Once armed, `bat_en_o` equals `vso_low_i` as sampled at the previous edge, through every later power-down and power-up.
- R11: The first power-up after reset passes through the same CER_CYCLES hold-off before the strobes are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_det_i | input | 1 | Synchronised power-fail detect, 1 = supply below threshold |
| vso_low_i | input | 1 | 1 = supply below backup-cell level |
| ce_n_i | input | 1 | Host chip enable, active low |
| we_n_i | input | 1 | Host write enable, active low |
| oe_n_i | input | 1 | Host output enable, active low |
| ce_n_o | output | 1 | Gated chip enable to memory |
| we_n_o | output | 1 | Gated write enable to memory |
| oe_n_o | output | 1 | Gated output enable to memory, 1 keeps data pins floating |
| wp_o | output | 1 | Registered write-protect flag |
| bat_en_o | output | 1 | Battery path select |

## Verification
The checker assumes that `pf_det_i` and `vso_low_i` are already synchronous to `clk`. It also assumes that an access in flight at detection starts with chip enable low, so that a sampled high chip enable during draining is a completion edge. The drain bound and the hold-off bound are measured in the checker by counting consecutive sampled high and low cycles of `pf_det_i`. Their stimulus therefore holds `pf_det_i` steady through each window, except in the deliberate re-assertion case. All stimulus changes on the falling clock edge, so that every sample is unambiguous.

// File: rtl/pfwp_pkg.sv
`timescale 1ns/1ps
package pfwp_pkg;

  typedef enum logic [2:0] {
    ST_UNARMED = 3'd0,
    ST_NORMAL  = 3'd1,
    ST_DRAIN   = 3'd2,
    ST_PROTECT = 3'd3,
    ST_RECOVER = 3'd4
  } pf_state_e;

  function automatic logic is_guarded(pf_state_e s);
    return (s == ST_UNARMED) || (s == ST_PROTECT) || (s == ST_RECOVER);
  endfunction

endpackage

// File: rtl/pfwp_interval.sv
`timescale 1ns/1ps
module pfwp_interval #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int unsigned LIM = (LIMIT < 2) ? 2 : LIMIT;
  localparam int unsigned CW  = $clog2(LIM);
  localparam logic [CW-1:0] LAST = CW'(LIM - 1);

  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pfwp_strobe_edge.sv
`timescale 1ns/1ps
module pfwp_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic ce_n_i,
  input  logic we_n_i,
  output logic done_o
);
  logic ce_prev_q;
  logic we_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_prev_q <= 1'b1;
      we_prev_q <= 1'b1;
    end else begin
      ce_prev_q <= ce_n_i;
      we_prev_q <= we_n_i;
    end
  end

  assign done_o = (ce_n_i & ~ce_prev_q) | (we_n_i & ~we_prev_q);
endmodule

// File: rtl/pfwp_fsm.sv
`timescale 1ns/1ps
module pfwp_fsm
  import pfwp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pf_det_i,
  input  logic      ce_n_i,
  input  logic      cycle_done,
  input  logic      drain_exp,
  input  logic      hold_exp,
  output pf_state_e st_q,
  output pf_state_e st_d,
  output logic      armed_d
);
  logic armed_q;

  assign armed_d = armed_q | ~pf_det_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_UNARMED: if (!pf_det_i) st_d = ST_RECOVER;
      ST_NORMAL:  if (pf_det_i)  st_d = ce_n_i ? ST_PROTECT : ST_DRAIN;
      ST_DRAIN:   if (cycle_done || drain_exp) st_d = ST_PROTECT;
      ST_PROTECT: if (!pf_det_i) st_d = ST_RECOVER;
      ST_RECOVER: begin
        if (pf_det_i)      st_d = ST_PROTECT;
        else if (hold_exp) st_d = ST_NORMAL;
      end
      default:    st_d = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_UNARMED;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/pfwp_outreg.sv
`timescale 1ns/1ps
module pfwp_outreg (
  input  logic clk,
  input  logic rst,
  input  logic guard_d,
  input  logic armed_d,
  input  logic vso_low_i,
  input  logic ce_n_i,
  input  logic we_n_i,
  input  logic oe_n_i,
  output logic ce_n_o,
  output logic we_n_o,
  output logic oe_n_o,
  output logic wp_o,
  output logic bat_en_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wp_o     <= 1'b1;
      ce_n_o   <= 1'b1;
      we_n_o   <= 1'b1;
      oe_n_o   <= 1'b1;
      bat_en_o <= 1'b0;
    end else begin
      wp_o     <= guard_d;
      ce_n_o   <= guard_d | ce_n_i;
      we_n_o   <= guard_d | we_n_i;
      oe_n_o   <= guard_d | oe_n_i;
      bat_en_o <= armed_d & vso_low_i;
    end
  end
endmodule

// File: rtl/pfwp_seq.sv
`timescale 1ns/1ps
module pfwp_seq
  import pfwp_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 125000,
  parameter int unsigned WPT_US     = 100,
  parameter int unsigned CER_MS     = 80,
  parameter int unsigned WPT_CYCLES = CLK_KHZ * WPT_US / 1000,
  parameter int unsigned CER_CYCLES = CLK_KHZ * CER_MS
) (
  input  logic clk,
  input  logic rst,
  input  logic pf_det_i,
  input  logic vso_low_i,
  input  logic ce_n_i,
  input  logic we_n_i,
  input  logic oe_n_i,
  output logic ce_n_o,
  output logic we_n_o,
  output logic oe_n_o,
  output logic wp_o,
  output logic bat_en_o
);
  pf_state_e st_q;
  pf_state_e st_d;
  logic      armed_d;
  logic      cycle_done;
  logic      drain_exp;
  logic      hold_exp;

  pfwp_strobe_edge edge_i (
    .clk    (clk),
    .rst    (rst),
    .ce_n_i (ce_n_i),
    .we_n_i (we_n_i),
    .done_o (cycle_done)
  );

  pfwp_interval #(.LIMIT(WPT_CYCLES)) drain_tmr_i (
    .clk     (clk),
    .rst     (rst),
    .run     (st_q == ST_DRAIN),
    .expired (drain_exp)
  );

  pfwp_interval #(.LIMIT(CER_CYCLES)) hold_tmr_i (
    .clk     (clk),
    .rst     (rst),
    .run     (st_q == ST_RECOVER),
    .expired (hold_exp)
  );

  pfwp_fsm fsm_i (
    .clk        (clk),
    .rst        (rst),
    .pf_det_i   (pf_det_i),
    .ce_n_i     (ce_n_i),
    .cycle_done (cycle_done),
    .drain_exp  (drain_exp),
    .hold_exp   (hold_exp),
    .st_q       (st_q),
    .st_d       (st_d),
    .armed_d    (armed_d)
  );

  pfwp_outreg out_i (
    .clk       (clk),
    .rst       (rst),
    .guard_d   (is_guarded(st_d)),
    .armed_d   (armed_d),
    .vso_low_i (vso_low_i),
    .ce_n_i    (ce_n_i),
    .we_n_i    (we_n_i),
    .oe_n_i    (oe_n_i),
    .ce_n_o    (ce_n_o),
    .we_n_o    (we_n_o),
    .oe_n_o    (oe_n_o),
    .wp_o      (wp_o),
    .bat_en_o  (bat_en_o)
  );
endmodule

// File: rtl/pfwp_seq_chk.sv
`timescale 1ns/1ps
module pfwp_seq_chk #(
  parameter int unsigned WPT_CYCLES = 2,
  parameter int unsigned CER_CYCLES = 2
) (
  input logic clk,
  input logic rst,
  input logic pf_det_i,
  input logic vso_low_i,
  input logic ce_n_i,
  input logic we_n_i,
  input logic oe_n_i,
  input logic ce_n_o,
  input logic we_n_o,
  input logic oe_n_o,
  input logic wp_o,
  input logic bat_en_o
);
  logic [31:0] hi_open_cnt;
  logic [31:0] lo_cnt;
  logic        seen_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_open_cnt <= '0;
      lo_cnt      <= '0;
      seen_valid  <= 1'b0;
    end else begin
      if (pf_det_i && !wp_o) begin
        if (hi_open_cnt != 32'hFFFF_FFFF) hi_open_cnt <= hi_open_cnt + 1;
      end else begin
        hi_open_cnt <= '0;
      end
      if (!pf_det_i) begin
        if (lo_cnt != 32'hFFFF_FFFF) lo_cnt <= lo_cnt + 1;
      end else begin
        lo_cnt <= '0;
      end
      seen_valid <= seen_valid | ~pf_det_i;
    end
  end

  p_guard_hold_r2: assert property (@(posedge clk) disable iff (rst)
    wp_o |-> (ce_n_o && we_n_o && oe_n_o));

  p_pass_through_r3: assert property (@(posedge clk) disable iff (rst)
    !wp_o |-> (ce_n_o == $past(ce_n_i)) && (we_n_o == $past(we_n_i)) && (oe_n_o == $past(oe_n_i)));

  p_idle_protect_r4: assert property (@(posedge clk) disable iff (rst)
    (pf_det_i && ce_n_i && !wp_o) |=> wp_o);

  p_drain_bound_r6: assert property (@(posedge clk) disable iff (rst)
    hi_open_cnt <= WPT_CYCLES + 1);

  p_holdoff_len_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(wp_o) |-> (lo_cnt > CER_CYCLES));

  p_stay_protected_r8: assert property (@(posedge clk) disable iff (rst)
    (wp_o && pf_det_i) |=> wp_o);

  p_isolated_r9: assert property (@(posedge clk) disable iff (rst)
    bat_en_o |-> seen_valid);

  p_bat_follow_r10: assert property (@(posedge clk) disable iff (rst)
    bat_en_o |-> $past(vso_low_i));
endmodule

bind pfwp_seq pfwp_seq_chk #(
  .WPT_CYCLES(WPT_CYCLES),
  .CER_CYCLES(CER_CYCLES)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .pf_det_i  (pf_det_i),
  .vso_low_i (vso_low_i),
  .ce_n_i    (ce_n_i),
  .we_n_i    (we_n_i),
  .oe_n_i    (oe_n_i),
  .ce_n_o    (ce_n_o),
  .we_n_o    (we_n_o),
  .oe_n_o    (oe_n_o),
  .wp_o      (wp_o),
  .bat_en_o  (bat_en_o)
);

// File: tb/pfwp_seq_tb.sv
`timescale 1ns/1ps
module pfwp_seq_tb_top;
  localparam int WPT = 6;
  localparam int CER = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pf_det_i = 1'b1;
  logic vso_low_i = 1'b1;
  logic ce_n_i = 1'b1;
  logic we_n_i = 1'b1;
  logic oe_n_i = 1'b1;
  logic ce_n_o, we_n_o, oe_n_o, wp_o, bat_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #HALF clk = ~clk;

  pfwp_seq #(.WPT_CYCLES(WPT), .CER_CYCLES(CER)) dut_i (
    .clk(clk), .rst(rst), .pf_det_i(pf_det_i), .vso_low_i(vso_low_i),
    .ce_n_i(ce_n_i), .we_n_i(we_n_i), .oe_n_i(oe_n_i),
    .ce_n_o(ce_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o),
    .wp_o(wp_o), .bat_en_o(bat_en_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic strobes(input logic c, input logic w, input logic o);
    ce_n_i = c; we_n_i = w; oe_n_i = o;
  endtask

  task automatic check_guarded(input string req);
    check(req, "wp_o", int'(wp_o), 1);
    check(req, "strobes_o", int'({ce_n_o, we_n_o, oe_n_o}), 7);
  endtask

  // pf falls now; wp must hold for CER edges and drop on the next observation
  task automatic do_recover(input string req);
    pf_det_i = 1'b0;
    for (int j = 1; j <= CER + 1; j++) begin
      cyc();
      check(req, "wp_o during hold-off", int'(wp_o), (j <= CER) ? 1 : 0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; pf_det_i = 1'b1; vso_low_i = 1'b1; strobes(1, 1, 1);
    repeat (3) cyc();
    check_guarded("R1");
    check("R1", "bat_en_o in reset", int'(bat_en_o), 0);
    rst = 1'b0;
    cyc();
    check_guarded("R1");
    check("R1", "bat_en_o after reset", int'(bat_en_o), 0);
    strobes(0, 0, 0);
    repeat (3) cyc();
    check_guarded("R2");
    check("R9", "bat_en_o before first valid supply", int'(bat_en_o), 0);
    strobes(1, 1, 1);
    cyc();
  endtask

  task automatic t_first_powerup();
    strobes(0, 1, 0);
    pf_det_i = 1'b0;
    cyc();
    check("R2", "strobes_o during first hold-off", int'({ce_n_o, we_n_o, oe_n_o}), 7);
    check("R10", "bat_en_o armed follows vso", int'(bat_en_o), 1);
    for (int j = 2; j <= CER + 1; j++) begin
      cyc();
      check("R11", "wp_o first hold-off", int'(wp_o), (j <= CER) ? 1 : 0);
    end
    check("R3", "ce_n_o released", int'(ce_n_o), 0);
    strobes(1, 1, 1);
    vso_low_i = 1'b0;
    cyc();
    check("R10", "bat_en_o drops with vso", int'(bat_en_o), 0);
  endtask

  task automatic t_normal();
    logic [2:0] pats [4] = '{3'b010, 3'b000, 3'b011, 3'b101};
    for (int k = 0; k < 4; k++) begin
      strobes(pats[k][2], pats[k][1], pats[k][0]);
      cyc();
      check("R3", "mirror", int'({ce_n_o, we_n_o, oe_n_o}), int'(pats[k]));
      check("R3", "wp_o", int'(wp_o), 0);
    end
    strobes(1, 1, 1);
    cyc();
  endtask

  task automatic t_pf_idle();
    pf_det_i = 1'b1;
    cyc();
    check("R4", "wp_o idle detect", int'(wp_o), 1);
    strobes(0, 0, 0);
    cyc();
    check_guarded("R2");
    strobes(1, 1, 1);
    do_recover("R7");
  endtask

  task automatic t_drain(input bit by_we);
    strobes(0, by_we ? 1'b0 : 1'b1, 1);
    cyc();
    pf_det_i = 1'b1;
    cyc();
    check("R5", "wp_o while draining", int'(wp_o), 0);
    check("R5", "ce_n_o while draining", int'(ce_n_o), 0);
    cyc();
    check("R5", "wp_o still draining", int'(wp_o), 0);
    if (by_we) we_n_i = 1'b1; else ce_n_i = 1'b1;
    cyc();
    check("R5", "wp_o after completion", int'(wp_o), 1);
    check("R5", "ce_n_o after completion", int'(ce_n_o), 1);
    strobes(1, 1, 1);
    do_recover("R7");
  endtask

  task automatic t_timeout();
    strobes(0, 1, 0);
    cyc();
    pf_det_i = 1'b1;
    for (int j = 1; j <= WPT + 1; j++) begin
      cyc();
      check("R6", "wp_o drain timeout", int'(wp_o), (j == WPT + 1) ? 1 : 0);
    end
    check("R6", "ce_n_o forced", int'(ce_n_o), 1);
    strobes(1, 1, 1);
    do_recover("R7");
  endtask

  task automatic t_reassert();
    pf_det_i = 1'b1;
    cyc();
    check("R4", "wp_o", int'(wp_o), 1);
    pf_det_i = 1'b0;
    repeat (5) cyc();
    check("R8", "wp_o mid hold-off", int'(wp_o), 1);
    pf_det_i = 1'b1;
    cyc();
    check("R8", "wp_o after re-assert", int'(wp_o), 1);
    cyc();
    check("R8", "wp_o still protected", int'(wp_o), 1);
    do_recover("R8");
  endtask

  task automatic t_battery();
    vso_low_i = 1'b1;
    cyc();
    check("R10", "bat_en_o normal", int'(bat_en_o), 1);
    pf_det_i = 1'b1;
    cyc();
    check("R10", "bat_en_o protected", int'(bat_en_o), 1);
    vso_low_i = 1'b0;
    cyc();
    check("R10", "bat_en_o supply back", int'(bat_en_o), 0);
    do_recover("R7");
  endtask

  initial begin
    t_reset();
    t_first_powerup();
    t_normal();
    t_pf_idle();
    t_drain(1'b0);
    t_drain(1'b1);
    t_timeout();
    t_reassert();
    t_battery();
    t_normal();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(2 * HALF * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule